// File: doc/BRIEF.md
# Eight-Point Complex FFT/IFFT Engine

This block computes an eight-point discrete Fourier transform of one frame of complex samples. A serial-to-parallel stage upstream presents all eight complex inputs at once and raises a start strobe. The engine copies them into a pair of register banks, one for real parts and one for imaginary parts. It then runs three radix-2 decimation-in-frequency passes on one shared set of four butterflies. Each pass writes its results back into the same banks. After the third pass it registers the eight outputs in natural order and raises a one-cycle done strobe.

A small controller walks through idle, load and three stage states. Its only job is to pick which routing and which set of twiddle factors feeds the butterflies. The datapath builds all three routings from constant index arithmetic, and a multiplexer selects one. A build-time parameter turns the engine into an inverse transform: it conjugates the twiddles and scales the outputs down by eight.

Top module: `fft8_engine`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `done_o` is 0 and every output word is zero.
- R2: A `start_i` sampled high in idle captures all sixteen input words on that same edge. `done_o` is then high for exactly one cycle, beginning four clock edges after the capture edge.
- R3: A `start_i` sampled during the four edges after an accepted start has no effect. No extra done pulse appears, and the outputs carry the result of the frame that was accepted.
- R4: With `INVERSE`=0, output k equals the DFT sum over n of x[n]·e^(−j2πnk/8). It is computed by three decimation-in-frequency passes with pair spans 4, 2 and 1, where the lower element of each pair becomes a+b and the upper becomes (a−b)·W^e. Inputs and outputs are in natural index order, word k at bits [16k+15:16k].
- R5: Samples and twiddles are signed Q8.8. Unity is 0x0100, and the 45° twiddle uses 0x00B5 (181) for both its cosine and sine magnitude.
- R6: Every sum and every rounded product is clamped to the range −32768 to 32767. A product is rounded by adding 128 to the 16-fraction-bit sum of partial products and then shifting it arithmetically right by 8.
- R7: With `INVERSE`=1, the imaginary parts of the twiddles are negated. Each final word is shifted arithmetically right by 3, which rounds toward minus infinity.
- R8: Output words change only on the edge that raises `done_o`, and they hold their values until the next done pulse.
- R9: A `start_i` sampled on the cycle in which `done_o` is high is accepted as a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Frame ready strobe, accepted only in idle |
| in_re | input | 8×DATA_W | Real parts of the eight input samples, Q8.8 |
| in_im | input | 8×DATA_W | Imaginary parts of the eight input samples, Q8.8 |
| done_o | output | 1 | One-cycle pulse when a new result is on the outputs |
| out_re | output | 8×DATA_W | Real parts of the result, natural order |
| out_im | output | 8×DATA_W | Imaginary parts of the result, natural order |

## Verification
The bench builds two copies of the block side by side, both with `DATA_W`=16 and `FRAC_W`=8. One has `INVERSE`=0 and the other has `INVERSE`=1, and both receive the same frames, so the conjugated twiddles and the divide-by-eight shift are checked against the forward results on identical data. The 16-bit Q8.8 width lets full-scale inputs reach the clamp limits, and it keeps the 181 constant exact, so hand-derived values such as a single sample at index 1 produce exact expected words. Start strobes held through the busy window, and a start given in the done cycle, exercise the controller edges.

// File: rtl/fft8_pkg.sv
package fft8_pkg;

  localparam int NPTS  = 8;
  localparam int NBFLY = NPTS / 2;
  localparam int NSTG  = $clog2(NPTS);
  localparam int SEL_W = $clog2(NSTG);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_STG1,
    ST_STG2,
    ST_STG3
  } fft_state_e;

  // index of the lower element of butterfly b in pass s (spans 4,2,1)
  function automatic int pair_lo(input int s, input int b);
    int h;
    h = NBFLY >> s;
    return (b / h) * 2 * h + (b % h);
  endfunction

  function automatic int pair_span(input int s);
    return NBFLY >> s;
  endfunction

  // twiddle exponent of butterfly b in pass s
  function automatic int tw_exp(input int s, input int b);
    return (b % (NBFLY >> s)) << s;
  endfunction

  function automatic int rev3(input int k);
    return ((k & 1) << 2) | (k & 2) | ((k >> 2) & 1);
  endfunction

endpackage

// File: rtl/fft8_ctrl.sv
module fft8_ctrl
  import fft8_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output logic             load_o,
  output logic             calc_o,
  output logic             last_o,
  output logic [SEL_W-1:0] stage_o,
  output logic             done_o
);

  fft_state_e state_q, state_d;
  logic       done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_LOAD;
      ST_LOAD: state_d = ST_STG1;
      ST_STG1: state_d = ST_STG2;
      ST_STG2: state_d = ST_STG3;
      ST_STG3: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_STG3);
    end
  end

  always_comb begin
    unique case (state_q)
      ST_STG2: stage_o = SEL_W'(1);
      ST_STG3: stage_o = SEL_W'(2);
      default: stage_o = SEL_W'(0);
    endcase
  end

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign calc_o = (state_q == ST_STG1) || (state_q == ST_STG2) || (state_q == ST_STG3);
  assign last_o = (state_q == ST_STG3);
  assign done_o = done_q;

endmodule

// File: rtl/fft8_bfly.sv
module fft8_bfly #(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 8,
  parameter int TW_W   = FRAC_W + 2
) (
  input  logic signed [DATA_W-1:0] a_re,
  input  logic signed [DATA_W-1:0] a_im,
  input  logic signed [DATA_W-1:0] b_re,
  input  logic signed [DATA_W-1:0] b_im,
  input  logic signed [TW_W-1:0]   w_re,
  input  logic signed [TW_W-1:0]   w_im,
  output logic signed [DATA_W-1:0] s_re,
  output logic signed [DATA_W-1:0] s_im,
  output logic signed [DATA_W-1:0] d_re,
  output logic signed [DATA_W-1:0] d_im
);

  localparam int EW = DATA_W + 1;
  localparam int PW = EW + TW_W;
  localparam int SW = PW + 1;
  localparam logic signed [SW-1:0] RND  = SW'(2 ** (FRAC_W - 1));
  localparam logic signed [SW-1:0] MAXV = SW'((2 ** (DATA_W - 1)) - 1);
  localparam logic signed [SW-1:0] MINV = SW'(-(2 ** (DATA_W - 1)));

  function automatic logic signed [DATA_W-1:0] clip(input logic signed [SW-1:0] v);
    if (v > MAXV) return MAXV[DATA_W-1:0];
    if (v < MINV) return MINV[DATA_W-1:0];
    return v[DATA_W-1:0];
  endfunction

  logic signed [EW-1:0] sum_re, sum_im, dif_re, dif_im;
  logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;
  logic signed [SW-1:0] acc_re, acc_im;

  always_comb begin
    sum_re = EW'(a_re) + EW'(b_re);
    sum_im = EW'(a_im) + EW'(b_im);
    dif_re = EW'(a_re) - EW'(b_re);
    dif_im = EW'(a_im) - EW'(b_im);
    p_rr   = PW'(dif_re) * PW'(w_re);
    p_ii   = PW'(dif_im) * PW'(w_im);
    p_ri   = PW'(dif_re) * PW'(w_im);
    p_ir   = PW'(dif_im) * PW'(w_re);
    acc_re = SW'(p_rr) - SW'(p_ii) + RND;
    acc_im = SW'(p_ri) + SW'(p_ir) + RND;
    s_re   = clip(SW'(sum_re));
    s_im   = clip(SW'(sum_im));
    d_re   = clip(acc_re >>> FRAC_W);
    d_im   = clip(acc_im >>> FRAC_W);
  end

endmodule

// File: rtl/fft8_engine.sv
module fft8_engine
  import fft8_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int FRAC_W  = 8,
  parameter bit INVERSE = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start_i,
  input  logic [NPTS-1:0][DATA_W-1:0]  in_re,
  input  logic [NPTS-1:0][DATA_W-1:0]  in_im,
  output logic                         done_o,
  output logic [NPTS-1:0][DATA_W-1:0]  out_re,
  output logic [NPTS-1:0][DATA_W-1:0]  out_im
);

  localparam int TW_W   = FRAC_W + 2;
  localparam int ONE    = 2 ** FRAC_W;
  localparam int C45    = $rtoi(0.7071067811865476 * real'(ONE) + 0.5);
  localparam int OUT_SH = INVERSE ? NSTG : 0;

  function automatic int twr(input int k);
    case (k)
      0:       return ONE;
      1:       return C45;
      2:       return 0;
      default: return -C45;
    endcase
  endfunction

  function automatic int twi(input int k);
    int v;
    case (k)
      0:       v = 0;
      1:       v = -C45;
      2:       v = -ONE;
      default: v = -C45;
    endcase
    return INVERSE ? -v : v;
  endfunction

  logic             load, calc, last;
  logic [SEL_W-1:0] stage;

  fft8_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .load_o  (load),
    .calc_o  (calc),
    .last_o  (last),
    .stage_o (stage),
    .done_o  (done_o)
  );

  logic signed [DATA_W-1:0] bank_re [NPTS];
  logic signed [DATA_W-1:0] bank_im [NPTS];
  logic signed [DATA_W-1:0] scat_re [NSTG][NPTS];
  logic signed [DATA_W-1:0] scat_im [NSTG][NPTS];
  logic signed [DATA_W-1:0] nxt_re  [NPTS];
  logic signed [DATA_W-1:0] nxt_im  [NPTS];

  for (genvar b = 0; b < NBFLY; b++) begin : g_bfly
    localparam int L0 = pair_lo(0, b);
    localparam int L1 = pair_lo(1, b);
    localparam int L2 = pair_lo(2, b);
    localparam int H0 = pair_span(0);
    localparam int H1 = pair_span(1);
    localparam int H2 = pair_span(2);
    localparam int K0 = tw_exp(0, b);
    localparam int K1 = tw_exp(1, b);
    localparam int K2 = tw_exp(2, b);

    logic signed [DATA_W-1:0] ar, ai, br, bi, sr, si, dr, di;
    logic signed [TW_W-1:0]   wr, wi;

    // stage routing selector: all three gathers exist, the stage picks one
    always_comb begin
      unique case (stage)
        SEL_W'(0): begin
          ar = bank_re[L0];      ai = bank_im[L0];
          br = bank_re[L0 + H0]; bi = bank_im[L0 + H0];
          wr = TW_W'(twr(K0));   wi = TW_W'(twi(K0));
        end
        SEL_W'(1): begin
          ar = bank_re[L1];      ai = bank_im[L1];
          br = bank_re[L1 + H1]; bi = bank_im[L1 + H1];
          wr = TW_W'(twr(K1));   wi = TW_W'(twi(K1));
        end
        default: begin
          ar = bank_re[L2];      ai = bank_im[L2];
          br = bank_re[L2 + H2]; bi = bank_im[L2 + H2];
          wr = TW_W'(twr(K2));   wi = TW_W'(twi(K2));
        end
      endcase
    end

    fft8_bfly #(
      .DATA_W (DATA_W),
      .FRAC_W (FRAC_W),
      .TW_W   (TW_W)
    ) u_bfly (
      .a_re (ar), .a_im (ai), .b_re (br), .b_im (bi),
      .w_re (wr), .w_im (wi),
      .s_re (sr), .s_im (si), .d_re (dr), .d_im (di)
    );

    // scatter of this butterfly's results for each pass
    assign scat_re[0][L0]      = sr;
    assign scat_im[0][L0]      = si;
    assign scat_re[0][L0 + H0] = dr;
    assign scat_im[0][L0 + H0] = di;
    assign scat_re[1][L1]      = sr;
    assign scat_im[1][L1]      = si;
    assign scat_re[1][L1 + H1] = dr;
    assign scat_im[1][L1 + H1] = di;
    assign scat_re[2][L2]      = sr;
    assign scat_im[2][L2]      = si;
    assign scat_re[2][L2 + H2] = dr;
    assign scat_im[2][L2 + H2] = di;
  end

  always_comb begin
    for (int e = 0; e < NPTS; e++) begin
      unique case (stage)
        SEL_W'(0): begin nxt_re[e] = scat_re[0][e]; nxt_im[e] = scat_im[0][e]; end
        SEL_W'(1): begin nxt_re[e] = scat_re[1][e]; nxt_im[e] = scat_im[1][e]; end
        default:   begin nxt_re[e] = scat_re[2][e]; nxt_im[e] = scat_im[2][e]; end
      endcase
    end
  end

  // in-place banks: filled on accept, overwritten by each pass
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < NPTS; e++) begin
        bank_re[e] <= '0;
        bank_im[e] <= '0;
      end
    end else if (load) begin
      for (int e = 0; e < NPTS; e++) begin
        bank_re[e] <= $signed(in_re[e]);
        bank_im[e] <= $signed(in_im[e]);
      end
    end else if (calc) begin
      for (int e = 0; e < NPTS; e++) begin
        bank_re[e] <= nxt_re[e];
        bank_im[e] <= nxt_im[e];
      end
    end
  end

  // output register with fixed bit-reversed wiring back to natural order
  for (genvar k = 0; k < NPTS; k++) begin : g_out
    localparam int SRC = rev3(k);
    always_ff @(posedge clk) begin
      if (rst) begin
        out_re[k] <= '0;
        out_im[k] <= '0;
      end else if (last) begin
        out_re[k] <= nxt_re[SRC] >>> OUT_SH;
        out_im[k] <= nxt_im[SRC] >>> OUT_SH;
      end
    end
  end

endmodule

// File: rtl/fft8_engine_chk.sv
module fft8_engine_chk
  import fft8_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        start_i,
  input logic                        done_o,
  input logic [NPTS-1:0][DATA_W-1:0] out_re,
  input logic [NPTS-1:0][DATA_W-1:0] out_im
);

  // independent occupancy count: 0 idle, 1..4 the busy edges after accept
  logic [2:0] occ;

  always_ff @(posedge clk) begin
    if (rst) occ <= 3'd0;
    else if (occ == 3'd0) occ <= start_i ? 3'd1 : 3'd0;
    else if (occ == 3'd4) occ <= 3'd0;
    else occ <= occ + 3'd1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!done_o && out_re == '0 && out_im == '0));

  p_done_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (occ == 3'd4) |=> done_o);

  p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_only_after_accept_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(occ) == 3'd4));

  p_hold_between_r8: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(out_re) && $stable(out_im)));

  p_back_to_back_r9: assert property (@(posedge clk) disable iff (rst)
    (done_o && start_i) |-> ##5 done_o);

endmodule

bind fft8_engine fft8_engine_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .done_o  (done_o),
  .out_re  (out_re),
  .out_im  (out_im)
);

// File: tb/fft8_engine_tb.sv
`timescale 1ns/1ps
module fft8_engine_tb;
  import fft8_pkg::*;

  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [NPTS-1:0][DW-1:0] din_re = '0, din_im = '0;
  logic [NPTS-1:0][DW-1:0] f_re, f_im, i_re, i_im;
  logic f_done, i_done;

  always #2 clk = ~clk;

  fft8_engine #(.DATA_W(DW), .FRAC_W(8), .INVERSE(1'b0)) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .in_re(din_re), .in_im(din_im),
    .done_o(f_done), .out_re(f_re), .out_im(f_im));

  fft8_engine #(.DATA_W(DW), .FRAC_W(8), .INVERSE(1'b1)) u_inv (
    .clk(clk), .rst(rst), .start_i(start), .in_re(din_re), .in_im(din_im),
    .done_o(i_done), .out_re(i_re), .out_im(i_im));

  int n_chk = 0;
  int n_fail = 0;
  int xr[NPTS], xi[NPTS];
  int efr[NPTS], efi[NPTS], eir[NPTS], eii[NPTS];

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int clamp16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  // reference model built from R4..R7
  task automatic model(input bit inv, output int yr[NPTS], output int yi[NPTS]);
    longint br[NPTS], bi[NPTS];
    int wre[4], wim[4];
    wre = '{256, 181, 0, -181};
    wim = '{0, -181, -256, -181};
    for (int n = 0; n < NPTS; n++) begin br[n] = xr[n]; bi[n] = xi[n]; end
    for (int s = 0; s < 3; s++) begin
      int h;
      h = 4 >> s;
      for (int g = 0; g < NPTS; g += 2 * h) begin
        for (int p = 0; p < h; p++) begin
          longint dr, di, wr, wi, ar, ai;
          int k;
          k  = p << s;
          wr = wre[k];
          wi = inv ? -wim[k] : wim[k];
          ar = br[g+p]; ai = bi[g+p];
          dr = ar - br[g+p+h];
          di = ai - bi[g+p+h];
          br[g+p]   = clamp16(ar + br[g+p+h]);
          bi[g+p]   = clamp16(ai + bi[g+p+h]);
          br[g+p+h] = clamp16((dr * wr - di * wi + 128) >>> 8);
          bi[g+p+h] = clamp16((dr * wi + di * wr + 128) >>> 8);
        end
      end
    end
    for (int k = 0; k < NPTS; k++) begin
      int src;
      src = ((k & 1) << 2) | (k & 2) | ((k >> 2) & 1);
      yr[k] = inv ? int'(br[src] >>> 3) : int'(br[src]);
      yi[k] = inv ? int'(bi[src] >>> 3) : int'(bi[src]);
    end
  endtask

  task automatic drive_inputs();
    for (int n = 0; n < NPTS; n++) begin
      din_re[n] = DW'(xr[n]);
      din_im[n] = DW'(xi[n]);
    end
    model(1'b0, efr, efi);
    model(1'b1, eir, eii);
  endtask

  task automatic check_outputs(input string req);
    for (int k = 0; k < NPTS; k++) begin
      chk(req, $sformatf("fwd re[%0d]", k), int'($signed(f_re[k])), efr[k]);
      chk(req, $sformatf("fwd im[%0d]", k), int'($signed(f_im[k])), efi[k]);
      chk("R7", $sformatf("inv re[%0d]", k), int'($signed(i_re[k])), eir[k]);
      chk("R7", $sformatf("inv im[%0d]", k), int'($signed(i_im[k])), eii[k]);
    end
  endtask

  // called at a negedge; returns at the negedge where done is high
  task automatic run_frame(input string req);
    drive_inputs();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= 4; c++) begin
      @(negedge clk);
      chk("R2", $sformatf("done at wait %0d", c), int'(f_done), int'(c == 4));
      chk("R2", $sformatf("inv done at wait %0d", c), int'(i_done), int'(c == 4));
    end
    check_outputs(req);
  endtask

  task automatic after_pulse();
    @(negedge clk);
    chk("R2", "done falls after one cycle", int'(f_done), 0);
    check_outputs("R8");
  endtask

  task automatic clear_x();
    for (int n = 0; n < NPTS; n++) begin xr[n] = 0; xi[n] = 0; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R2 watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681357));
    repeat (3) @(negedge clk);
    chk("R1", "done in reset", int'(f_done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "done after reset", int'(f_done), 0);
    chk("R1", "fwd outputs zero", int'(f_re == '0 && f_im == '0), 1);
    chk("R1", "inv outputs zero", int'(i_re == '0 && i_im == '0), 1);

    // impulse at index 0: flat spectrum
    clear_x(); xr[0] = 256;
    run_frame("R4");
    after_pulse();

    // constant 1.0: all energy in bin 0
    clear_x();
    for (int n = 0; n < NPTS; n++) xr[n] = 256;
    run_frame("R4");
    chk("R4", "dc bin", int'($signed(f_re[0])), 2048);
    after_pulse();

    // single sample at index 1 exposes the 45 degree constant
    clear_x(); xr[1] = 256;
    run_frame("R5");
    chk("R5", "bin1 re = 0x00B5", int'($signed(f_re[1])), 181);
    chk("R5", "bin1 im = -0x00B5", int'($signed(f_im[1])), -181);
    chk("R7", "inv bin1 re", int'($signed(i_re[1])), 22);
    chk("R7", "inv bin1 im", int'($signed(i_im[1])), 22);
    after_pulse();

    // full-scale inputs drive the clamp
    for (int n = 0; n < NPTS; n++) begin xr[n] = 32767; xi[n] = -32768; end
    run_frame("R6");
    chk("R6", "dc re clamped", int'($signed(f_re[0])), 32767);
    chk("R6", "dc im clamped", int'($signed(f_im[0])), -32768);
    after_pulse();

    // alternating full-scale: clamp in the twiddle path
    for (int n = 0; n < NPTS; n++) begin xr[n] = (n % 2) ? -32768 : 32767; xi[n] = 0; end
    run_frame("R6");
    after_pulse();

    // start held through the busy window is ignored
    clear_x(); xr[2] = 300; xi[5] = -700; xr[7] = 1234;
    drive_inputs();
    start = 1'b1;
    @(negedge clk);
    for (int n = 0; n < NPTS; n++) begin din_re[n] = 16'h1111; din_im[n] = 16'h7abc; end
    for (int c = 1; c <= 4; c++) begin
      @(negedge clk);
      chk("R3", $sformatf("done while busy, wait %0d", c), int'(f_done), int'(c == 4));
    end
    start = 1'b0;
    check_outputs("R3");
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk("R3", "no second done", int'(f_done), 0);
    end
    check_outputs("R3");

    // back-to-back: start given in the done cycle
    clear_x(); xr[3] = -512; xi[1] = 640;
    run_frame("R4");
    for (int n = 0; n < NPTS; n++) begin
      xr[n] = int'($urandom_range(0, 4095)) - 2048;
      xi[n] = int'($urandom_range(0, 4095)) - 2048;
    end
    run_frame("R9");
    after_pulse();

    // random frames, mixed ranges
    for (int f = 0; f < 24; f++) begin
      for (int n = 0; n < NPTS; n++) begin
        if (f % 4 == 3) begin
          xr[n] = int'($urandom_range(0, 65535)) - 32768;
          xi[n] = int'($urandom_range(0, 65535)) - 32768;
        end else begin
          xr[n] = int'($urandom_range(0, 2047)) - 1024;
          xi[n] = int'($urandom_range(0, 2047)) - 1024;
        end
      end
      run_frame(f % 4 == 3 ? "R6" : "R4");
      if (f % 2 == 0) after_pulse();
    end
    repeat (2) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule